// File: doc/BRIEF.md
# Wrapping Page-Write Register Controller

This block sits behind a byte-oriented serial slave front end in a four-channel digitally controlled resistor device. The front end opens a transfer by giving a page number and a starting channel offset. It then offers data bytes one at a time and closes the transfer with a stop pulse. The block stores each accepted byte in a four-entry staging page. The slot is chosen by a channel offset counter that wraps inside the page and never moves to the next page. Each byte is also copied at once into the live wiper register of its channel.

On stop, the block checks two gates: an enable bit in its status register and a write-protect pin. If both allow it, a nonvolatile commit starts. The commit is modelled as a fixed countdown. While it runs, the busy output is high and every input is refused. When the countdown ends, only the staged entries that were written are copied into the chosen page of the sixteen-register data array. If either gate blocks the commit, the staged bytes are dropped and the array is left as it was.

Top module: `page_wrap_writer`

## Requirements
- R1: After reset, all sixteen data registers, all four wiper registers and the status register read zero, and `ack_o` and `busy_o` are low.
- R2: A transfer opened with page p and offset k sends its first byte to channel k of page p. That register is data index 4*p+k, seen at `nvreg_o[8*(4*p+k) +: 8]`.
- R3: Each accepted data byte gives a one-cycle `ack_o` pulse in the cycle after it is offered, and the channel offset advances by one.
- R4: The offset wraps from 3 back to 0 within the same page. Three bytes opened at page 2, offset 2 land in channels 2, 3 and 0, and a fourth byte lands in channel 1.
- R5: When more than four bytes arrive in one transfer, later bytes overwrite earlier ones in the same wrapped order.
- R6: Each accepted byte appears in the wiper register of its channel (`wiper_o[8*k +: 8]`) in the cycle after it is offered, whether or not a commit follows.
- R7: A commit starts only when status bit 0 (the nonvolatile enable) is 1. With the bit at 0, stop leaves the data array unchanged and the staged bytes are dropped. The status register is written through `stat_we_i`/`stat_d_i`.
- R8: If `wp_i` is high when stop is accepted, no commit starts and the staged bytes are dropped.
- R9: An allowed stop raises `busy_o` in the next cycle and holds it high for exactly COMMIT_CYCLES cycles. When busy falls, only the page entries written in this transfer are updated. A stop that follows no data byte starts no commit.
- R10: While `busy_o` is high, data bytes, start, stop and status writes are all ignored: no ack is given, and the wipers, status and pending commit are unchanged.
- R11: A data byte offered in the same cycle as the stop is accepted and is part of the commit. A data byte offered in the same cycle as a start is dropped without an ack.
- R12: A data byte or stop offered when no transfer is open (after a stop or a commit, before the next start) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a transfer |
| start_page_i | input | 2 | Page number for the transfer |
| start_off_i | input | 2 | Starting channel offset |
| byte_vld_i | input | 1 | Data byte offered |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Closes the transfer |
| wp_i | input | 1 | Write-protect; high blocks the commit |
| stat_we_i | input | 1 | Status register write strobe |
| stat_d_i | input | 8 | Status write data; bit 0 is the nonvolatile enable |
| ack_o | output | 1 | Pulse acknowledging an accepted byte |
| busy_o | output | 1 | Nonvolatile commit in progress |
| stat_o | output | 8 | Status register |
| nvreg_o | output | 128 | Data array; register 4*p+k in bits 8*(4p+k)+:8 |
| wiper_o | output | 32 | Wiper registers; channel k in bits 8k+:8 |

## Verification
Two functions can fall in the same cycle. The final byte of a transfer can arrive together with the stop, and a new start can arrive together with a byte. The bench drives byte and stop in one cycle and checks three things: the byte is acked, it reaches its wiper, and it is included in the committed page. It also drives start and byte together and checks that no ack appears and the wipers do not move. A further overlap is input offered during the commit countdown. This is judged by checking that no ack appears and that the status and wipers are unchanged after busy falls.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int PKG_CH_N    = 4;
    localparam int PKG_PAGE_N  = 4;
    localparam int PKG_DATA_W  = 8;
    localparam int PKG_STAT_W  = 8;
    localparam int PKG_COMMIT  = 16;
    // status bit that enables nonvolatile commits
    localparam int NVEN_BIT    = 0;

    typedef struct packed {
        logic ack;
    } ctl_t;
endpackage

// File: rtl/pgw_stage.sv
module pgw_stage #(
    parameter int CH_N   = 4,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 2,
    parameter int PG_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [PG_W-1:0]          page_i,
    input  logic [OFF_W-1:0]         off_i,
    input  logic                     byte_we_i,
    input  logic [DATA_W-1:0]        data_i,
    input  logic                     stop_i,
    output logic                     active_o,
    output logic [PG_W-1:0]          page_o,
    output logic [OFF_W-1:0]         off_o,
    output logic [CH_N-1:0]          valid_o,
    output logic [CH_N*DATA_W-1:0]   buf_o
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(CH_N - 1);

    typedef struct packed {
        logic                   active;
        logic [PG_W-1:0]        page;
        logic [OFF_W-1:0]       off;
        logic [CH_N-1:0]        valid;
        logic [CH_N*DATA_W-1:0] pbuf;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.page   = page_i;
            st_d.off    = off_i;
            st_d.valid  = '0;
        end else begin
            if (byte_we_i) begin
                st_d.pbuf[int'(st_q.off)*DATA_W +: DATA_W] = data_i;
                st_d.valid[st_q.off] = 1'b1;
                // offset wraps inside the page; page number never moves
                st_d.off = (st_q.off == LAST_OFF) ? '0 : st_q.off + 1'b1;
            end
            if (stop_i) begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign page_o   = st_q.page;
    assign off_o    = st_q.off;
    assign valid_o  = st_q.valid;
    assign buf_o    = st_q.pbuf;
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
    parameter int CYCLES = 16,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic busy_o,
    output logic done_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.busy) begin
            if (tm_q.cnt == CNT_W'(1)) begin
                tm_d.busy = 1'b0;
                tm_d.cnt  = '0;
            end else begin
                tm_d.cnt = tm_q.cnt - 1'b1;
            end
        end else if (launch_i) begin
            tm_d.busy = 1'b1;
            tm_d.cnt  = CNT_W'(CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign busy_o = tm_q.busy;
    assign done_o = tm_q.busy && (tm_q.cnt == CNT_W'(1));
endmodule

// File: rtl/pgw_regbank.sv
module pgw_regbank #(
    parameter int CH_N   = 4,
    parameter int PAGE_N = 4,
    parameter int DATA_W = 8,
    parameter int STAT_W = 8,
    parameter int OFF_W  = 2,
    parameter int PG_W   = 2,
    localparam int NV_W  = PAGE_N * CH_N * DATA_W,
    localparam int WP_W  = CH_N * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wip_we_i,
    input  logic [OFF_W-1:0]   wip_ch_i,
    input  logic [DATA_W-1:0]  wip_data_i,
    input  logic               commit_i,
    input  logic [PG_W-1:0]    commit_page_i,
    input  logic [CH_N-1:0]    commit_valid_i,
    input  logic [WP_W-1:0]    commit_buf_i,
    input  logic               stat_we_i,
    input  logic [STAT_W-1:0]  stat_d_i,
    output logic [NV_W-1:0]    nvreg_o,
    output logic [WP_W-1:0]    wiper_o,
    output logic [STAT_W-1:0]  stat_o
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [NV_W-1:0]   nv;
        logic [WP_W-1:0]   wip;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (stat_we_i) begin
            bk_d.stat = stat_d_i;
        end
        if (wip_we_i) begin
            bk_d.wip[int'(wip_ch_i)*DATA_W +: DATA_W] = wip_data_i;
        end
        for (int p = 0; p < PAGE_N; p++) begin
            for (int c = 0; c < CH_N; c++) begin
                if (commit_i && (commit_page_i == PG_W'(p)) && commit_valid_i[c]) begin
                    bk_d.nv[(p*CH_N + c)*DATA_W +: DATA_W] =
                        commit_buf_i[c*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign nvreg_o = bk_q.nv;
    assign wiper_o = bk_q.wip;
    assign stat_o  = bk_q.stat;
endmodule

// File: rtl/page_wrap_writer.sv
module page_wrap_writer
    import pgw_pkg::*;
#(
    parameter int CH_N          = PKG_CH_N,
    parameter int PAGE_N        = PKG_PAGE_N,
    parameter int DATA_W        = PKG_DATA_W,
    parameter int STAT_W        = PKG_STAT_W,
    parameter int COMMIT_CYCLES = PKG_COMMIT,
    localparam int OFF_W        = $clog2(CH_N),
    localparam int PG_W         = $clog2(PAGE_N)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [PG_W-1:0]                 start_page_i,
    input  logic [OFF_W-1:0]                start_off_i,
    input  logic                            byte_vld_i,
    input  logic [DATA_W-1:0]               byte_i,
    input  logic                            stop_i,
    input  logic                            wp_i,
    input  logic                            stat_we_i,
    input  logic [STAT_W-1:0]               stat_d_i,
    output logic                            ack_o,
    output logic                            busy_o,
    output logic [STAT_W-1:0]               stat_o,
    output logic [PAGE_N*CH_N*DATA_W-1:0]   nvreg_o,
    output logic [CH_N*DATA_W-1:0]          wiper_o
);
    logic                   busy, done;
    logic                   active;
    logic [PG_W-1:0]        cur_page;
    logic [OFF_W-1:0]       cur_off;
    logic [CH_N-1:0]        valid;
    logic [CH_N*DATA_W-1:0] pbuf;
    logic                   acc_start, acc_byte, acc_stop, acc_stat, launch;
    ctl_t                   ctl_d, ctl_q;

    // acceptance: commit refuses all input; start outranks a same-cycle byte
    always_comb begin
        acc_start = start_i && !busy;
        acc_byte  = byte_vld_i && !busy && active && !start_i;
        acc_stop  = stop_i && !busy && active && !start_i;
        acc_stat  = stat_we_i && !busy;
        launch    = acc_stop && stat_o[NVEN_BIT] && !wp_i && ((|valid) || acc_byte);
        ctl_d     = ctl_q;
        ctl_d.ack = acc_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pgw_stage #(
        .CH_N   (CH_N),
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W),
        .PG_W   (PG_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (acc_start),
        .page_i    (start_page_i),
        .off_i     (start_off_i),
        .byte_we_i (acc_byte),
        .data_i    (byte_i),
        .stop_i    (acc_stop),
        .active_o  (active),
        .page_o    (cur_page),
        .off_o     (cur_off),
        .valid_o   (valid),
        .buf_o     (pbuf)
    );

    pgw_timer #(
        .CYCLES (COMMIT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .busy_o   (busy),
        .done_o   (done)
    );

    pgw_regbank #(
        .CH_N   (CH_N),
        .PAGE_N (PAGE_N),
        .DATA_W (DATA_W),
        .STAT_W (STAT_W),
        .OFF_W  (OFF_W),
        .PG_W   (PG_W)
    ) u_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .wip_we_i       (acc_byte),
        .wip_ch_i       (cur_off),
        .wip_data_i     (byte_i),
        .commit_i       (done),
        .commit_page_i  (cur_page),
        .commit_valid_i (valid),
        .commit_buf_i   (pbuf),
        .stat_we_i      (acc_stat),
        .stat_d_i       (stat_d_i),
        .nvreg_o        (nvreg_o),
        .wiper_o        (wiper_o),
        .stat_o         (stat_o)
    );

    assign ack_o  = ctl_q.ack;
    assign busy_o = busy;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int COMMIT_CYCLES = 16,
    parameter int NV_W          = 128,
    parameter int WP_W          = 32,
    parameter int STAT_W        = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld_i,
    input logic              stop_i,
    input logic              wp_i,
    input logic              ack_o,
    input logic              busy_o,
    input logic [STAT_W-1:0] stat_o,
    input logic [NV_W-1:0]   nvreg_o,
    input logic [WP_W-1:0]   wiper_o
);
    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_run <= 0;
        else if (busy_o) busy_run <= busy_run + 1;
        else             busy_run <= 0;
    end

    a_r3_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(byte_vld_i));

    a_r10_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !ack_o);

    a_r10_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(wiper_o));

    a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(stat_o));

    a_r9_nv_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(nvreg_o));

    a_r9_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_run == COMMIT_CYCLES));

    a_r8_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && wp_i && !busy_o) |=> !busy_o);

    a_r7_nven_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && !stat_o[0]) |=> !busy_o);
endmodule

bind page_wrap_writer pgw_checker #(
    .COMMIT_CYCLES (COMMIT_CYCLES),
    .NV_W          (PAGE_N*CH_N*DATA_W),
    .WP_W          (CH_N*DATA_W),
    .STAT_W        (STAT_W)
) u_pgw_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld_i (byte_vld_i),
    .stop_i     (stop_i),
    .wp_i       (wp_i),
    .ack_o      (ack_o),
    .busy_o     (busy_o),
    .stat_o     (stat_o),
    .nvreg_o    (nvreg_o),
    .wiper_o    (wiper_o)
);

// File: tb/page_wrap_writer_bench.sv
module page_wrap_writer_bench;
    localparam int CLK_NS  = 10;
    localparam int NCOMMIT = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i, byte_vld_i, stop_i, wp_i, stat_we_i;
    logic [1:0]   start_page_i, start_off_i;
    logic [7:0]   byte_i, stat_d_i;
    logic         ack_o, busy_o;
    logic [7:0]   stat_o;
    logic [127:0] nvreg_o;
    logic [31:0]  wiper_o;

    int checks = 0;
    int failures = 0;

    logic [7:0] m_nv [16];
    logic [7:0] m_wp [4];
    logic [7:0] m_buf [4];
    logic [3:0] m_valid;
    int         m_page, m_off;

    always #(CLK_NS/2) clk = ~clk;

    page_wrap_writer #(.COMMIT_CYCLES(NCOMMIT)) u_page_wrap_writer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_page_i(start_page_i),
        .start_off_i(start_off_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .stop_i(stop_i), .wp_i(wp_i), .stat_we_i(stat_we_i), .stat_d_i(stat_d_i),
        .ack_o(ack_o), .busy_o(busy_o), .stat_o(stat_o), .nvreg_o(nvreg_o),
        .wiper_o(wiper_o)
    );

    function automatic logic [127:0] nv_exp();
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = m_nv[i];
        return v;
    endfunction

    function automatic logic [127:0] wp_exp();
        logic [127:0] v = '0;
        for (int i = 0; i < 4; i++) v[i*8 +: 8] = m_wp[i];
        return v;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_start(input int pg, input int off);
        m_page = pg; m_off = off; m_valid = '0;
    endtask

    task automatic model_byte(input logic [7:0] b);
        m_buf[m_off] = b; m_valid[m_off] = 1'b1; m_wp[m_off] = b;
        m_off = (m_off + 1) % 4;
    endtask

    task automatic model_commit();
        for (int c = 0; c < 4; c++) if (m_valid[c]) m_nv[m_page*4 + c] = m_buf[c];
    endtask

    task automatic drive_start(input int pg, input int off);
        start_i = 1'b1; start_page_i = 2'(pg); start_off_i = 2'(off);
        @(negedge clk);
        start_i = 1'b0;
        model_start(pg, off);
    endtask

    task automatic drive_byte(input logic [7:0] b, input logic exp_ack, input string req);
        byte_vld_i = 1'b1; byte_i = b;
        @(negedge clk);
        byte_vld_i = 1'b0;
        if (exp_ack) model_byte(b);
        chk(req, "ack", ack_o, exp_ack);
        chk(req, "wipers", wiper_o, wp_exp());
    endtask

    task automatic stat_write(input logic [7:0] v);
        stat_we_i = 1'b1; stat_d_i = v;
        @(negedge clk);
        stat_we_i = 1'b0;
        chk("R7", "status write", stat_o, v);
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    // stop with exact busy-length timing, then array compare
    task automatic stop_commit(input string req);
        pulse_stop();
        chk("R9", "busy after stop", busy_o, 1'b1);
        for (int i = 1; i < NCOMMIT; i++) begin
            @(negedge clk);
            chk("R9", "busy held", busy_o, 1'b1);
            if (i == NCOMMIT - 1) chk("R9", "array before end", nvreg_o, nv_exp());
        end
        @(negedge clk);
        model_commit();
        chk("R9", "busy dropped", busy_o, 1'b0);
        chk(req, "array after commit", nvreg_o, nv_exp());
    endtask

    task automatic wait_idle(input string req);
        for (int i = 0; i < 4*NCOMMIT && busy_o; i++) @(negedge clk);
        model_commit();
        chk(req, "idle after commit", busy_o, 1'b0);
        chk(req, "array after commit", nvreg_o, nv_exp());
    endtask

    task automatic t_reset();
        chk("R1", "ack", ack_o, 1'b0);
        chk("R1", "busy", busy_o, 1'b0);
        chk("R1", "status", stat_o, 8'h00);
        chk("R1", "array", nvreg_o, '0);
        chk("R1", "wipers", wiper_o, '0);
    endtask

    task automatic t_basic();
        stat_write(8'h01);
        drive_start(1, 0);
        drive_byte(8'h10, 1'b1, "R3");
        drive_byte(8'h11, 1'b1, "R3");
        drive_byte(8'h12, 1'b1, "R6");
        drive_byte(8'h13, 1'b1, "R6");
        stop_commit("R2");
        chk("R2", "page1 ch0", nvreg_o[8*4 +: 8], 8'h10);
    endtask

    task automatic t_wrap();
        drive_start(2, 2);
        drive_byte(8'hA0, 1'b1, "R4");
        drive_byte(8'hA1, 1'b1, "R4");
        drive_byte(8'hA2, 1'b1, "R4");
        chk("R4", "third byte in ch0", wiper_o[7:0], 8'hA2);
        drive_byte(8'hA3, 1'b1, "R4");
        chk("R4", "fourth byte in ch1", wiper_o[15:8], 8'hA3);
        stop_commit("R4");
        chk("R4", "page2 ch3", nvreg_o[8*11 +: 8], 8'hA1);
    endtask

    task automatic t_overflow();
        drive_start(3, 1);
        for (int i = 0; i < 6; i++) drive_byte(8'hB0 + 8'(i), 1'b1, "R5");
        chk("R5", "ch1 overwritten", wiper_o[15:8], 8'hB4);
        chk("R5", "ch2 overwritten", wiper_o[23:16], 8'hB5);
        stop_commit("R5");
        chk("R5", "page3 ch3", nvreg_o[8*15 +: 8], 8'hB2);
        chk("R5", "page3 ch0", nvreg_o[8*12 +: 8], 8'hB3);
    endtask

    task automatic t_busy_ignore();
        drive_start(0, 0);
        drive_byte(8'h11, 1'b1, "R10");
        pulse_stop();
        chk("R10", "busy", busy_o, 1'b1);
        byte_vld_i = 1'b1; byte_i = 8'hEE;
        @(negedge clk);
        byte_vld_i = 1'b0;
        chk("R10", "no ack while busy", ack_o, 1'b0);
        chk("R10", "wipers held", wiper_o, wp_exp());
        start_i = 1'b1; start_page_i = 2'd3; start_off_i = 2'd3;
        @(negedge clk);
        start_i = 1'b0;
        stat_we_i = 1'b1; stat_d_i = 8'h00;
        @(negedge clk);
        stat_we_i = 1'b0;
        chk("R10", "status held", stat_o, 8'h01);
        pulse_stop();
        wait_idle("R10");
        chk("R10", "status after", stat_o, 8'h01);
        drive_byte(8'h77, 1'b0, "R12");
        pulse_stop();
        chk("R12", "stop without transfer", busy_o, 1'b0);
    endtask

    task automatic t_nven_off();
        stat_write(8'h00);
        drive_start(3, 0);
        drive_byte(8'h5A, 1'b1, "R6");
        pulse_stop();
        chk("R7", "no commit", busy_o, 1'b0);
        chk("R7", "array kept", nvreg_o, nv_exp());
        chk("R6", "wiper mirrored", wiper_o[7:0], 8'h5A);
        stat_write(8'h01);
        drive_start(3, 1);
        drive_byte(8'h66, 1'b1, "R7");
        stop_commit("R7");
        chk("R7", "dropped byte absent", nvreg_o[8*12 +: 8], 8'hB3);
    endtask

    task automatic t_wp();
        drive_start(2, 1);
        drive_byte(8'h99, 1'b1, "R8");
        wp_i = 1'b1;
        pulse_stop();
        wp_i = 1'b0;
        chk("R8", "no commit", busy_o, 1'b0);
        chk("R8", "array kept", nvreg_o, nv_exp());
        drive_start(2, 3);
        drive_byte(8'hC1, 1'b1, "R8");
        stop_commit("R8");
        chk("R8", "dropped byte absent", nvreg_o[8*9 +: 8], 8'hA3);
    endtask

    task automatic t_same_cycle();
        start_i = 1'b1; start_page_i = 2'd1; start_off_i = 2'd3;
        byte_vld_i = 1'b1; byte_i = 8'hCC;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
        model_start(1, 3);
        chk("R11", "byte with start dropped", ack_o, 1'b0);
        chk("R11", "wipers unchanged", wiper_o, wp_exp());
        drive_byte(8'hD3, 1'b1, "R11");
        byte_vld_i = 1'b1; byte_i = 8'hD0; stop_i = 1'b1;
        @(negedge clk);
        byte_vld_i = 1'b0; stop_i = 1'b0;
        model_byte(8'hD0);
        chk("R11", "ack with stop", ack_o, 1'b1);
        chk("R11", "commit launched", busy_o, 1'b1);
        chk("R11", "wiper ch0", wiper_o[7:0], 8'hD0);
        wait_idle("R11");
        chk("R11", "page1 ch0", nvreg_o[8*4 +: 8], 8'hD0);
    endtask

    task automatic t_empty_stop();
        drive_start(0, 2);
        pulse_stop();
        chk("R9", "no commit without bytes", busy_o, 1'b0);
        @(negedge clk);
        chk("R9", "still idle", busy_o, 1'b0);
    endtask

    initial begin
        #(CLK_NS * 100000);
        failures++;
        $display("FAIL watchdog all-R actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_nv[i] = 8'h00;
        for (int i = 0; i < 4; i++) begin m_wp[i] = 8'h00; m_buf[i] = 8'h00; end
        m_valid = '0; m_page = 0; m_off = 0;
        rst_n = 1'b0; start_i = 1'b0; byte_vld_i = 1'b0; stop_i = 1'b0; wp_i = 1'b0;
        stat_we_i = 1'b0; start_page_i = '0; start_off_i = '0; byte_i = '0; stat_d_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_overflow();
        t_busy_ignore();
        t_nven_off();
        t_wp();
        t_same_cycle();
        t_empty_stop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule